// File: doc/BRIEF.md
# Effective Address Sequencer

This block resolves the operand address of an 8-bit processor instruction once its opcode has been fetched. It issues the bus cycles that the addressing mode calls for, one per clock, and keeps the dummy accesses the bus must show. These are the read of an unindexed zero-page byte, the read of a not-yet-corrected indexed address, and the page-fixup read of a branch. When the sequence ends it reports the effective address and the number of bus cycles it used. Executing the instruction is not part of this block.

A request carries an addressing-mode code, the address of the first operand byte, the X and Y index values, a read flag, a write flag (both set means read-modify-write) and a branch-taken flag. It is accepted when `startValid` and `startReady` are both high. Each bus cycle is a read or a write request that stays on the port until `memReady` is high. Read data returns in that same cycle. `done` pulses for one cycle after the last transfer, and `effAddr` and `cycleCount` are valid while `done` is high.

Mode codes: 0 immediate, 1 zero page, 2 zero page+X, 3 zero page+Y, 4 absolute, 5 absolute+X, 6 absolute+Y, 7 (zero page+X) indirect, 8 (zero page) indirect+Y, 9 indirect jump, 10 relative branch, 11 to 15 implied. The first transfer of every mode is a read at `startPc`.

Top module: `eff_addr_gen`

## Requirements
- R1: A request is accepted only while `startReady` is high, and `startReady` stays low from acceptance until after `done`. `done` is high for exactly one cycle, in the cycle after the last transfer.
- R2: A bus request holds its address and kind while `memReady` is low. A transfer completes only in a cycle with `memReady` high. Read and write strobes are never high together.
- R3: Zero page+X/Y (codes 2, 3) read the operand at P and then make a dummy read at 0x00nn, where nn is the operand. The effective address is 0x00 followed by (nn + index) mod 256. With the read flag set, a data read at that address follows.
- R4: Absolute+X/Y (codes 5, 6) read low and high at P and P+1, then read {high, (low+index) mod 256}. A second read at the full 16-bit sum follows only when low+index exceeds 0xFF or the request is read-modify-write. Write-only requests never make the second read.
- R5: Indirect+Y (code 8) reads zero-page byte zp at P, then pointer low at 0x00zp and pointer high at 0x00(zp+1 mod 256). It then behaves as R4 with Y and that pointer.
- R6: (Zero page+X) indirect (code 7) reads zp at P, makes a dummy read at 0x00zp, and reads pointer bytes at 0x00t and 0x00(t+1 mod 256), with t = (zp+X) mod 256. The read flag adds a data read at the pointer.
- R7: Indirect jump (code 9) reads pointer bytes at P and P+1, then reads the target low byte at the pointer. It reads the target high byte at {pointer high, (pointer low + 1) mod 256}, so there is no carry into the pointer's page. No data read follows.
- R8: Relative branch (code 10) reads the offset at P. The target is P+1 plus the signed offset. Not taken costs 1 cycle. Taken costs 2 cycles, with a read at {page of P+1, target low}. When that page differs from the target page there is a third read, at the target.
- R9: Read-modify-write requests in modes 1 to 8 follow the data read with a write of the unchanged read byte to the effective address.
- R10: `cycleCount` at `done` equals the number of completed transfers of the request.
- R11: After reset the block is idle: `startReady` high, no bus strobe, `done` low.
- R12: Immediate (code 0) and implied (codes 11 to 15) make one read at P, with effective address P. Zero page (code 1) and absolute (code 4) read their operand bytes and add a data read only when the read flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Request present |
| startReady | output | 1 | Block can accept a request |
| startMode | input | 4 | Addressing-mode code |
| startPc | input | 16 | Address of the first operand byte |
| startX | input | 8 | X index value |
| startY | input | 8 | Y index value |
| startRead | input | 1 | Instruction reads its operand |
| startWrite | input | 1 | Instruction writes its operand |
| startTaken | input | 1 | Branch condition is true |
| memRd | output | 1 | Read request |
| memWr | output | 1 | Write request |
| memAddr | output | 16 | Bus address |
| memWdata | output | 8 | Write data (unchanged read byte) |
| memRdata | input | 8 | Read data, valid with memReady |
| memReady | input | 1 | Transfer completes this cycle |
| done | output | 1 | Sequence finished |
| effAddr | output | 16 | Effective address, valid with done |
| cycleCount | output | 4 | Completed transfers, valid with done |

## Verification
The assertions check the port protocol on every cycle: a stalled request stays put, the two strobes never overlap, `done` is a single-cycle pulse during which no request can be accepted, and a write-back hits the effective address just read. Which addresses each mode visits, in what order, and whether the fix-up, pointer-wrap and branch-page cycles appear at all depend on the operand bytes, so only the bench's directed scenarios can show them. Each scenario compares the complete recorded transfer list, the effective address and the cycle count against values worked out by hand.

// File: rtl/eag_pkg.sv
package eag_pkg;

  typedef enum logic [3:0] {
    AM_IMMED = 4'd0,
    AM_ZP    = 4'd1,
    AM_ZPX   = 4'd2,
    AM_ZPY   = 4'd3,
    AM_ABS   = 4'd4,
    AM_ABSX  = 4'd5,
    AM_ABSY  = 4'd6,
    AM_PREX  = 4'd7,
    AM_POSTY = 4'd8,
    AM_JIND  = 4'd9,
    AM_REL   = 4'd10,
    AM_IMPL  = 4'd11
  } amode_t;

  typedef enum logic [3:0] {
    SEL_PC,
    SEL_PC1,
    SEL_ZBASE,
    SEL_ZPTR,
    SEL_ZPTR1,
    SEL_RAWIDX,
    SEL_EA,
    SEL_JLO,
    SEL_JHI,
    SEL_BRRAW
  } asel_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OP1,
    ST_OP2,
    ST_ZDUM,
    ST_PLO,
    ST_PHI,
    ST_IDXRD,
    ST_JLO,
    ST_JHI,
    ST_BR1,
    ST_BR2,
    ST_DATA,
    ST_WB,
    ST_DONE
  } state_t;

  typedef struct packed {
    logic  busRd;
    logic  busWr;
    logic  ldStart;
    asel_t sel;
    logic  ldLo;
    logic  ldHi;
    logic  ldPtr;
    logic  bumpPtr;
    logic  ldTgtLo;
    logic  ldTgtHi;
    logic  ldData;
  } ctl_t;

endpackage

// File: rtl/eag_ctrl.sv
module eag_ctrl
  import eag_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startValid,
  input  logic [3:0] startMode,
  input  logic       startRead,
  input  logic       startWrite,
  input  logic       startTaken,
  input  logic       memReady,
  input  logic       idxCarry,
  input  logic       brCross,
  output logic       startReady,
  output logic       done,
  output amode_t     curMode,
  output ctl_t       ctl
);

  state_t st, nxt;
  amode_t modeR;
  logic   rdF, wrF, takenF;
  logic   fire;
  state_t afterEa;

  assign curMode = modeR;
  assign fire    = (ctl.busRd | ctl.busWr) & memReady;
  assign afterEa = rdF ? ST_DATA : ST_DONE;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st     <= ST_IDLE;
      modeR  <= AM_IMPL;
      rdF    <= 1'b0;
      wrF    <= 1'b0;
      takenF <= 1'b0;
    end else begin
      st <= nxt;
      if (st == ST_IDLE && startValid) begin
        modeR  <= (startMode > 4'd10) ? AM_IMPL : amode_t'(startMode);
        rdF    <= startRead;
        wrF    <= startWrite;
        takenF <= startTaken;
      end
    end
  end

  always_comb begin
    ctl        = '0;
    ctl.sel    = SEL_PC;
    nxt        = st;
    startReady = 1'b0;
    done       = 1'b0;
    unique case (st)
      ST_IDLE: begin
        startReady = 1'b1;
        if (startValid) begin
          ctl.ldStart = 1'b1;
          nxt         = ST_OP1;
        end
      end
      ST_OP1: begin
        ctl.busRd = 1'b1;
        ctl.sel   = SEL_PC;
        ctl.ldLo  = 1'b1;
        ctl.ldPtr = 1'b1;
        if (fire) begin
          case (modeR)
            AM_ZP:                       nxt = afterEa;
            AM_ZPX, AM_ZPY, AM_PREX:     nxt = ST_ZDUM;
            AM_ABS, AM_ABSX, AM_ABSY,
            AM_JIND:                     nxt = ST_OP2;
            AM_POSTY:                    nxt = ST_PLO;
            AM_REL:                      nxt = takenF ? ST_BR1 : ST_DONE;
            default:                     nxt = ST_DONE;
          endcase
        end
      end
      ST_OP2: begin
        ctl.busRd = 1'b1;
        ctl.sel   = SEL_PC1;
        ctl.ldHi  = 1'b1;
        if (fire) begin
          case (modeR)
            AM_ABS:  nxt = afterEa;
            AM_JIND: nxt = ST_JLO;
            default: nxt = ST_IDXRD;
          endcase
        end
      end
      ST_ZDUM: begin
        ctl.busRd   = 1'b1;
        ctl.sel     = SEL_ZBASE;
        ctl.bumpPtr = (modeR == AM_PREX);
        if (fire) nxt = (modeR == AM_PREX) ? ST_PLO : afterEa;
      end
      ST_PLO: begin
        ctl.busRd = 1'b1;
        ctl.sel   = SEL_ZPTR;
        ctl.ldLo  = 1'b1;
        if (fire) nxt = ST_PHI;
      end
      ST_PHI: begin
        ctl.busRd = 1'b1;
        ctl.sel   = SEL_ZPTR1;
        ctl.ldHi  = 1'b1;
        if (fire) nxt = (modeR == AM_PREX) ? afterEa : ST_IDXRD;
      end
      ST_IDXRD: begin
        ctl.busRd  = 1'b1;
        ctl.sel    = SEL_RAWIDX;
        ctl.ldData = 1'b1;
        if (fire) nxt = (rdF && (idxCarry || wrF)) ? ST_DATA : ST_DONE;
      end
      ST_JLO: begin
        ctl.busRd   = 1'b1;
        ctl.sel     = SEL_JLO;
        ctl.ldTgtLo = 1'b1;
        if (fire) nxt = ST_JHI;
      end
      ST_JHI: begin
        ctl.busRd   = 1'b1;
        ctl.sel     = SEL_JHI;
        ctl.ldTgtHi = 1'b1;
        if (fire) nxt = ST_DONE;
      end
      ST_BR1: begin
        ctl.busRd = 1'b1;
        ctl.sel   = SEL_BRRAW;
        if (fire) nxt = brCross ? ST_BR2 : ST_DONE;
      end
      ST_BR2: begin
        ctl.busRd = 1'b1;
        ctl.sel   = SEL_EA;
        if (fire) nxt = ST_DONE;
      end
      ST_DATA: begin
        ctl.busRd  = 1'b1;
        ctl.sel    = SEL_EA;
        ctl.ldData = 1'b1;
        if (fire) nxt = (rdF && wrF) ? ST_WB : ST_DONE;
      end
      ST_WB: begin
        ctl.busWr = 1'b1;
        ctl.sel   = SEL_EA;
        if (fire) nxt = ST_DONE;
      end
      ST_DONE: begin
        done = 1'b1;
        nxt  = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/eag_dp.sv
module eag_dp
  import eag_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  amode_t            curMode,
  input  logic [3:0]        startMode,
  input  logic [ADDR_W-1:0] startPc,
  input  logic [DATA_W-1:0] startX,
  input  logic [DATA_W-1:0] startY,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [ADDR_W-1:0] effAddr,
  output logic [CNT_W-1:0]  cycleCount,
  output logic              idxCarry,
  output logic              brCross
);

  localparam logic [DATA_W-1:0] ZPAGE = '0;

  logic [ADDR_W-1:0] pcR;
  logic [DATA_W-1:0] idxR, baseLo, baseHi, zpPtr, tgtLo, tgtHi, dataR;
  logic [CNT_W-1:0]  cnt;
  logic              fire;
  logic              useY;
  logic [DATA_W:0]   sum;
  logic [ADDR_W-1:0] npc, offExt, tgt, eaComb;

  assign fire = (ctl.busRd | ctl.busWr) & memReady;
  assign useY = (startMode == 4'(AM_ZPY)) || (startMode == 4'(AM_ABSY)) ||
                (startMode == 4'(AM_POSTY));

  assign sum      = {1'b0, baseLo} + {1'b0, idxR};
  assign idxCarry = sum[DATA_W];
  assign npc      = pcR + ADDR_W'(1);
  assign offExt   = {{DATA_W{baseLo[DATA_W-1]}}, baseLo};
  assign tgt      = npc + offExt;
  assign brCross  = tgt[ADDR_W-1:DATA_W] != npc[ADDR_W-1:DATA_W];

  always_comb begin
    unique case (curMode)
      AM_ZP:                       eaComb = {ZPAGE, baseLo};
      AM_ZPX, AM_ZPY:              eaComb = {ZPAGE, sum[DATA_W-1:0]};
      AM_ABS, AM_PREX:             eaComb = {baseHi, baseLo};
      AM_ABSX, AM_ABSY, AM_POSTY:  eaComb = {baseHi, baseLo} + {ZPAGE, idxR};
      AM_JIND:                     eaComb = {tgtHi, tgtLo};
      AM_REL:                      eaComb = tgt;
      default:                     eaComb = pcR;
    endcase
  end

  always_comb begin
    unique case (ctl.sel)
      SEL_PC:     memAddr = pcR;
      SEL_PC1:    memAddr = npc;
      SEL_ZBASE:  memAddr = {ZPAGE, baseLo};
      SEL_ZPTR:   memAddr = {ZPAGE, zpPtr};
      SEL_ZPTR1:  memAddr = {ZPAGE, zpPtr + DATA_W'(1)};
      SEL_RAWIDX: memAddr = {baseHi, sum[DATA_W-1:0]};
      SEL_JLO:    memAddr = {baseHi, baseLo};
      SEL_JHI:    memAddr = {baseHi, baseLo + DATA_W'(1)};
      SEL_BRRAW:  memAddr = {npc[ADDR_W-1:DATA_W], tgt[DATA_W-1:0]};
      default:    memAddr = eaComb;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcR    <= '0;
      idxR   <= '0;
      baseLo <= '0;
      baseHi <= '0;
      zpPtr  <= '0;
      tgtLo  <= '0;
      tgtHi  <= '0;
      dataR  <= '0;
      cnt    <= '0;
    end else begin
      if (ctl.ldStart) begin
        pcR  <= startPc;
        idxR <= useY ? startY : startX;
        cnt  <= '0;
      end
      if (fire) begin
        cnt <= cnt + CNT_W'(1);
        if (ctl.ldLo)    baseLo <= memRdata;
        if (ctl.ldHi)    baseHi <= memRdata;
        if (ctl.ldPtr)   zpPtr  <= memRdata;
        if (ctl.bumpPtr) zpPtr  <= zpPtr + idxR;
        if (ctl.ldTgtLo) tgtLo  <= memRdata;
        if (ctl.ldTgtHi) tgtHi  <= memRdata;
        if (ctl.ldData)  dataR  <= memRdata;
      end
    end
  end

  assign memWdata   = dataR;
  assign effAddr    = eaComb;
  assign cycleCount = cnt;

endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
  import eag_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  output logic              startReady,
  input  logic [3:0]        startMode,
  input  logic [ADDR_W-1:0] startPc,
  input  logic [DATA_W-1:0] startX,
  input  logic [DATA_W-1:0] startY,
  input  logic              startRead,
  input  logic              startWrite,
  input  logic              startTaken,
  output logic              memRd,
  output logic              memWr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memReady,
  output logic              done,
  output logic [ADDR_W-1:0] effAddr,
  output logic [CNT_W-1:0]  cycleCount
);

  ctl_t   ctl;
  amode_t curMode;
  logic   idxCarry, brCross;

  eag_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .startMode  (startMode),
    .startRead  (startRead),
    .startWrite (startWrite),
    .startTaken (startTaken),
    .memReady   (memReady),
    .idxCarry   (idxCarry),
    .brCross    (brCross),
    .startReady (startReady),
    .done       (done),
    .curMode    (curMode),
    .ctl        (ctl)
  );

  eag_dp #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .curMode    (curMode),
    .startMode  (startMode),
    .startPc    (startPc),
    .startX     (startX),
    .startY     (startY),
    .memReady   (memReady),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .effAddr    (effAddr),
    .cycleCount (cycleCount),
    .idxCarry   (idxCarry),
    .brCross    (brCross)
  );

  assign memRd = ctl.busRd;
  assign memWr = ctl.busWr;

endmodule

// File: rtl/eag_checker.sv
module eag_checker #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4,
  localparam int ADDR_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              startReady,
  input logic              memRd,
  input logic              memWr,
  input logic              memReady,
  input logic [ADDR_W-1:0] memAddr,
  input logic              done,
  input logic [ADDR_W-1:0] effAddr,
  input logic [CNT_W-1:0]  cycleCount
);

  assert_excl_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> !memWr);

  assert_hold_stall_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && !memReady) |=> (memRd && $stable(memAddr)));

  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || memWr || done) |-> !startReady);

  assert_wb_after_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWr) |-> ($past(memRd) && ($past(memAddr) == memAddr)));

  assert_wb_at_ea_R9: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> (memAddr == effAddr));

  assert_count_range_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (cycleCount != '0 && cycleCount <= CNT_W'(6)));

endmodule

bind eff_addr_gen eag_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startReady (startReady),
  .memRd      (memRd),
  .memWr      (memWr),
  .memReady   (memReady),
  .memAddr    (memAddr),
  .done       (done),
  .effAddr    (effAddr),
  .cycleCount (cycleCount)
);

// File: tb/sim_eff_addr_gen.sv
module sim_eff_addr_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic        startReady;
  logic [3:0]  startMode = '0;
  logic [15:0] startPc = '0;
  logic [7:0]  startX = '0;
  logic [7:0]  startY = '0;
  logic        startRead = 1'b0;
  logic        startWrite = 1'b0;
  logic        startTaken = 1'b0;
  logic        memRd, memWr;
  logic [15:0] memAddr;
  logic [7:0]  memWdata;
  logic [7:0]  memRdata;
  logic        memReady = 1'b1;
  logic        done;
  logic [15:0] effAddr;
  logic [3:0]  cycleCount;

  int checks = 0;
  int fails  = 0;
  logic stallEn = 1'b0;

  always #2 clk = ~clk;

  eff_addr_gen u0 (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startReady(startReady),
    .startMode(startMode), .startPc(startPc), .startX(startX), .startY(startY),
    .startRead(startRead), .startWrite(startWrite), .startTaken(startTaken),
    .memRd(memRd), .memWr(memWr), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memReady(memReady), .done(done), .effAddr(effAddr),
    .cycleCount(cycleCount)
  );

  // sparse memory: poked bytes, else a pattern of the address
  logic [15:0] pkA [16];
  logic [7:0]  pkD [16];
  int          pkN = 0;

  always_comb begin
    memRdata = memAddr[7:0] ^ memAddr[15:8] ^ 8'hA5;
    for (int i = 0; i < 16; i++)
      if (i < pkN && pkA[i] == memAddr) memRdata = pkD[i];
  end

  task automatic poke(input logic [15:0] a, input logic [7:0] d);
    pkA[pkN] = a;
    pkD[pkN] = d;
    pkN++;
  endtask

  always @(posedge clk) begin
    #1;
    if (stallEn) memReady = ~memReady;
    else         memReady = 1'b1;
  end

  // transfer trace, sampled mid-cycle
  logic [15:0] trA [8];
  logic        trW [8];
  logic [7:0]  trD [8];
  int          trN = 0;

  always @(negedge clk) begin
    if ((memRd || memWr) && memReady && trN < 8) begin
      trA[trN] = memAddr;
      trW[trN] = memWr;
      trD[trN] = memWdata;
      trN++;
    end
  end

  logic [15:0] expA [8];
  logic        expW [8];
  logic [7:0]  expD [8];
  int          expN = 0;
  logic [15:0] gotEa;
  logic [3:0]  gotCnt;
  logic        gotDone;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h exp %h", tag, what, act, exp);
    end
  endtask

  task automatic ex(input logic [15:0] a, input logic w, input logic [7:0] d);
    expA[expN] = a;
    expW[expN] = w;
    expD[expN] = d;
    expN++;
  endtask

  task automatic runOp(input logic [3:0] m, input logic [15:0] pc,
                       input logic [7:0] xv, input logic [7:0] yv,
                       input logic rd, input logic wr, input logic tk);
    @(posedge clk); #1;
    trN = 0;
    startMode = m; startPc = pc; startX = xv; startY = yv;
    startRead = rd; startWrite = wr; startTaken = tk;
    startValid = 1'b1;
    do @(negedge clk); while (!startReady);
    @(posedge clk); #1;
    startValid = 1'b0;
    gotDone = 1'b0;
    for (int k = 0; k < 60 && !gotDone; k++) begin
      @(negedge clk);
      if (done) begin
        gotDone = 1'b1;
        gotEa   = effAddr;
        gotCnt  = cycleCount;
      end
    end
  endtask

  task automatic verify(input string tag, input logic [15:0] ea);
    check(tag, "done seen (R1)", gotDone, 1'b1);
    check(tag, "transfer count", trN, expN);
    for (int i = 0; i < expN && i < trN; i++) begin
      check(tag, $sformatf("xfer%0d addr", i), trA[i], expA[i]);
      check(tag, $sformatf("xfer%0d write", i), trW[i], expW[i]);
      if (expW[i]) check(tag, $sformatf("xfer%0d wdata", i), trD[i], expD[i]);
    end
    check(tag, "effAddr", gotEa, ea);
    check(tag, "cycleCount (R10)", gotCnt, 4'(expN));
    expN = 0;
    pkN  = 0;
  endtask

  task automatic tReset;
    @(negedge clk);
    check("R11", "startReady", startReady, 1'b1);
    check("R11", "memRd", memRd, 1'b0);
    check("R11", "memWr", memWr, 1'b0);
    check("R11", "done", done, 1'b0);
  endtask

  task automatic tBasic;  // R12
    runOp(4'd0, 16'h1234, 8'h00, 8'h00, 1, 0, 0);
    ex(16'h1234, 0, 0); verify("R12 immediate", 16'h1234);
    runOp(4'd13, 16'h2222, 8'h00, 8'h00, 1, 0, 0);
    ex(16'h2222, 0, 0); verify("R12 implied", 16'h2222);
    poke(16'h2000, 8'h80);
    runOp(4'd1, 16'h2000, 8'h00, 8'h00, 1, 0, 0);
    ex(16'h2000, 0, 0); ex(16'h0080, 0, 0); verify("R12 zp read", 16'h0080);
    poke(16'h3000, 8'h34); poke(16'h3001, 8'h12);
    runOp(4'd4, 16'h3000, 8'h00, 8'h00, 0, 1, 0);
    ex(16'h3000, 0, 0); ex(16'h3001, 0, 0); verify("R12 abs write", 16'h1234);
  endtask

  task automatic tZpIdx;  // R3
    poke(16'h4000, 8'hF0);
    runOp(4'd2, 16'h4000, 8'h20, 8'h00, 1, 0, 0);
    ex(16'h4000, 0, 0); ex(16'h00F0, 0, 0); ex(16'h0010, 0, 0);
    verify("R3 zpx wrap", 16'h0010);
    poke(16'h4000, 8'h10);
    runOp(4'd3, 16'h4000, 8'h77, 8'h05, 0, 1, 0);
    ex(16'h4000, 0, 0); ex(16'h0010, 0, 0);
    verify("R3 zpy write", 16'h0015);
  endtask

  task automatic tAbsIdx;  // R4
    poke(16'h5000, 8'h10); poke(16'h5001, 8'h22);
    runOp(4'd5, 16'h5000, 8'h05, 8'h00, 1, 0, 0);
    ex(16'h5000, 0, 0); ex(16'h5001, 0, 0); ex(16'h2215, 0, 0);
    verify("R4 absx no carry", 16'h2215);
    poke(16'h5000, 8'hF0); poke(16'h5001, 8'h22);
    runOp(4'd6, 16'h5000, 8'h00, 8'h20, 1, 0, 0);
    ex(16'h5000, 0, 0); ex(16'h5001, 0, 0); ex(16'h2210, 0, 0); ex(16'h2310, 0, 0);
    verify("R4 absy carry", 16'h2310);
    poke(16'h5000, 8'hF0); poke(16'h5001, 8'h22);
    runOp(4'd5, 16'h5000, 8'h20, 8'h00, 0, 1, 0);
    ex(16'h5000, 0, 0); ex(16'h5001, 0, 0); ex(16'h2210, 0, 0);
    verify("R4 absx write carry", 16'h2310);
  endtask

  task automatic tRmw;  // R9
    poke(16'h5000, 8'h10); poke(16'h5001, 8'h22); poke(16'h2215, 8'hA7);
    runOp(4'd5, 16'h5000, 8'h05, 8'h00, 1, 1, 0);
    ex(16'h5000, 0, 0); ex(16'h5001, 0, 0); ex(16'h2215, 0, 0);
    ex(16'h2215, 0, 0); ex(16'h2215, 1, 8'hA7);
    verify("R9 R4 absx rmw", 16'h2215);
    poke(16'hA000, 8'h33); poke(16'h0033, 8'h5C);
    runOp(4'd1, 16'hA000, 8'h00, 8'h00, 1, 1, 0);
    ex(16'hA000, 0, 0); ex(16'h0033, 0, 0); ex(16'h0033, 1, 8'h5C);
    verify("R9 zp rmw", 16'h0033);
  endtask

  task automatic tPostY;  // R5
    poke(16'h6000, 8'h40); poke(16'h0040, 8'hF8); poke(16'h0041, 8'h30);
    runOp(4'd8, 16'h6000, 8'h00, 8'h10, 1, 0, 0);
    ex(16'h6000, 0, 0); ex(16'h0040, 0, 0); ex(16'h0041, 0, 0);
    ex(16'h3008, 0, 0); ex(16'h3108, 0, 0);
    verify("R5 posty carry", 16'h3108);
    poke(16'h6000, 8'hFF); poke(16'h00FF, 8'h00); poke(16'h0000, 8'h44);
    runOp(4'd8, 16'h6000, 8'h00, 8'h02, 1, 0, 0);
    ex(16'h6000, 0, 0); ex(16'h00FF, 0, 0); ex(16'h0000, 0, 0); ex(16'h4402, 0, 0);
    verify("R5 posty ptr wrap", 16'h4402);
  endtask

  task automatic tPreX;  // R6
    poke(16'h7000, 8'hFE); poke(16'h00FF, 8'h78); poke(16'h0000, 8'h56);
    runOp(4'd7, 16'h7000, 8'h01, 8'h00, 1, 0, 0);
    ex(16'h7000, 0, 0); ex(16'h00FE, 0, 0); ex(16'h00FF, 0, 0);
    ex(16'h0000, 0, 0); ex(16'h5678, 0, 0);
    verify("R6 prex wrap", 16'h5678);
  endtask

  task automatic tJind;  // R7
    poke(16'h8000, 8'hFF); poke(16'h8001, 8'h02);
    poke(16'h02FF, 8'h34); poke(16'h0200, 8'h12);
    runOp(4'd9, 16'h8000, 8'h00, 8'h00, 1, 0, 0);
    ex(16'h8000, 0, 0); ex(16'h8001, 0, 0); ex(16'h02FF, 0, 0); ex(16'h0200, 0, 0);
    verify("R7 jind page wrap", 16'h1234);
  endtask

  task automatic tBranch;  // R8
    poke(16'h9000, 8'h10);
    runOp(4'd10, 16'h9000, 8'h00, 8'h00, 0, 0, 0);
    ex(16'h9000, 0, 0); verify("R8 not taken", 16'h9011);
    poke(16'h9000, 8'h10);
    runOp(4'd10, 16'h9000, 8'h00, 8'h00, 0, 0, 1);
    ex(16'h9000, 0, 0); ex(16'h9011, 0, 0); verify("R8 taken same page", 16'h9011);
    poke(16'h9000, 8'hF0);
    runOp(4'd10, 16'h9000, 8'h00, 8'h00, 0, 0, 1);
    ex(16'h9000, 0, 0); ex(16'h90F1, 0, 0); ex(16'h8FF1, 0, 0);
    verify("R8 taken cross", 16'h8FF1);
  endtask

  task automatic tStall;  // R2, R1
    stallEn = 1'b1;
    poke(16'h3000, 8'h34); poke(16'h3001, 8'h12);
    runOp(4'd4, 16'h3000, 8'h00, 8'h00, 1, 0, 0);
    ex(16'h3000, 0, 0); ex(16'h3001, 0, 0); ex(16'h1234, 0, 0);
    verify("R2 stalled abs", 16'h1234);
    stallEn = 1'b0;
    @(negedge clk);
    check("R1", "ready after done", startReady, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tReset();
    tBasic();
    tZpIdx();
    tAbsIdx();
    tRmw();
    tPostY();
    tPreX();
    tJind();
    tBranch();
    tStall();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R1 watchdog: got timeout exp completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule